// File: doc/BRIEF.md
# Smart Card Hardware Activation Sequencer

This block runs the power-up and power-down sequence of a smart card contact interface when a host command line, not software, drives it. A falling edge on the active-low command line starts activation. Activation needs hardware mode to be selected and a card to be present. The sequencer then connects the card I/O lines and starts the card supply, at the voltage class the class-select input shows at that moment. It enables the card clock once the supply reports it has settled and the host holds its reset input low. After the host reset has been seen low, the card reset pin follows the host reset input, so the host's own rising edge on that input releases the card from reset.

A rising edge on the command line powers the card down in four steps, one per clock: reset low, clock off, I/O disconnected, supply off. Pulling the card out starts the same power-down and sets a fault flag, which stays set until the next activation starts. When hardware mode is not selected, the card reset pin carries the software reset bit and the command line has no effect. All inputs are synchronous to `clk`. The analog regulator and the clock source sit outside this block.

Top module: `sc_hwact_seq`

## Requirements
- R1: While `rst_n` is low and on the first edge after it, `io_connect`, `supply_en`, `supply_class`, `clk_en`, `card_rst` (with `hw_mode`=1) and `fault` are all 0.
- R2: With `hw_mode`=1 and `card_present`=1 in the idle state, a 1-to-0 transition of `host_cmd_n` between two clock edges sets `io_connect` on the next edge. `supply_en` follows one edge later, never earlier.
- R3: If `card_present` is 0 when the falling edge of `host_cmd_n` is sampled, activation does not start: `io_connect` and `supply_en` stay 0.
- R4: `supply_class` takes the value of `class_sel` at the edge that starts activation (1 = class A, 5 V; 0 = class B, 3 V). Changes to `class_sel` while the card is active have no effect.
- R5: `clk_en` rises on the edge after one where the supply phase samples `supply_ok`=1 and `host_rst`=0 together. It stays 0 while either condition is missing.
- R6: In hardware mode `card_rst` is 0 until `host_rst` has been sampled at 0 during the supply phase. From then on `card_rst` equals `host_rst` without a register delay, so a rising edge on `host_rst` raises `card_rst`.
- R7: With `hw_mode`=0, `card_rst` equals `sw_rst`, and edges on `host_cmd_n` start no activation.
- R8: A 0-to-1 transition of `host_cmd_n` during activation drops `card_rst` on the next edge. `clk_en`, `io_connect` and `supply_en` then fall on the three edges that follow, one per edge, in that order.
- R9: `card_present`=0 in any non-idle state starts the R8 power-down and sets `fault`. `fault` stays 1 until the edge that starts the next activation, which clears it.
- R10: A falling edge of `host_cmd_n` while the power-down is running is ignored. The sequencer returns to idle with all outputs off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_mode | input | 1 | 1 = hardware activation path, 0 = software reset path |
| sw_rst | input | 1 | Software card reset bit used when `hw_mode`=0 |
| host_cmd_n | input | 1 | Active-low host activation command line |
| card_present | input | 1 | Card detected in the connector |
| class_sel | input | 1 | Voltage class request, 1 = 5 V, 0 = 3 V |
| host_rst | input | 1 | Host reset input forwarded to the card |
| supply_ok | input | 1 | Card supply has settled |
| supply_en | output | 1 | Card supply enable |
| supply_class | output | 1 | Latched voltage class, 1 = 5 V, 0 = 3 V |
| io_connect | output | 1 | Card I/O lines connected to host I/O lines |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Card reset line |
| fault | output | 1 | Card removed while not idle |

## Verification
The assertions assume that every input is synchronous to `clk` and changes only between edges. They also assume that `supply_ok` is meaningful only while the supply is enabled. The bench drives every input 1 ns after a rising edge, so each value is stable before the next edge. It lowers `supply_ok` before it starts each new activation. It sweeps both voltage classes, four supply-settling delays and both orders of host-reset-low versus supply-settled. Card removal, a missing card and software mode are each covered by their own sequences.

// File: rtl/sc_act_pkg.sv
package sc_act_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CONNECT = 3'd1,
    ST_POWER   = 3'd2,
    ST_RUN     = 3'd3,
    ST_DROP    = 3'd4,
    ST_STOPCLK = 3'd5,
    ST_UNPLUG  = 3'd6
  } act_state_t;
endpackage

// File: rtl/sc_line_edge.sv
module sc_line_edge #(
  parameter int WIDTH = 1,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line,
  output logic [WIDTH-1:0] fall,
  output logic [WIDTH-1:0] rise
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LEVEL;
      else        prev_q <= line[g];
    end
    assign fall[g] = prev_q & ~line[g];
    assign rise[g] = ~prev_q & line[g];
  end
endmodule

// File: rtl/sc_act_fsm.sv
module sc_act_fsm
  import sc_act_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hw_mode,
  input  logic cmd_fall,
  input  logic cmd_rise,
  input  logic card_present,
  input  logic class_sel,
  input  logic host_rst,
  input  logic supply_ok,
  output logic io_q,
  output logic sup_q,
  output logic cls_q,
  output logic clk_q,
  output logic linked_q,
  output logic fault_q
);
  act_state_t state_q;
  logic       active;
  logic       stop_req;

  assign active   = (state_q == ST_CONNECT) || (state_q == ST_POWER) || (state_q == ST_RUN);
  assign stop_req = cmd_rise | ~card_present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      io_q     <= 1'b0;
      sup_q    <= 1'b0;
      cls_q    <= 1'b0;
      clk_q    <= 1'b0;
      linked_q <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      if (state_q != ST_IDLE && !card_present) fault_q <= 1'b1;
      if (active && stop_req) begin
        state_q  <= ST_DROP;
        linked_q <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (hw_mode && cmd_fall && card_present) begin
              state_q <= ST_CONNECT;
              io_q    <= 1'b1;
              cls_q   <= class_sel;
              fault_q <= 1'b0;
            end
          end
          ST_CONNECT: begin
            state_q <= ST_POWER;
            sup_q   <= 1'b1;
          end
          ST_POWER: begin
            if (!host_rst) linked_q <= 1'b1;
            if (supply_ok && !host_rst) begin
              state_q <= ST_RUN;
              clk_q   <= 1'b1;
            end
          end
          ST_RUN: begin
            if (!host_rst) linked_q <= 1'b1;
          end
          ST_DROP: begin
            state_q <= ST_STOPCLK;
            clk_q   <= 1'b0;
          end
          ST_STOPCLK: begin
            state_q <= ST_UNPLUG;
            io_q    <= 1'b0;
          end
          ST_UNPLUG: begin
            state_q <= ST_IDLE;
            sup_q   <= 1'b0;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sc_rst_mux.sv
module sc_rst_mux #(
  parameter int WIDTH = 1
) (
  input  logic             hw_sel,
  input  logic [WIDTH-1:0] sw_src,
  input  logic [WIDTH-1:0] host_src,
  input  logic [WIDTH-1:0] link_en,
  output logic [WIDTH-1:0] rst_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_path
    assign rst_out[g] = hw_sel ? (host_src[g] & link_en[g]) : sw_src[g];
  end
endmodule

// File: rtl/sc_hwact_seq.sv
module sc_hwact_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_mode,
  input  logic sw_rst,
  input  logic host_cmd_n,
  input  logic card_present,
  input  logic class_sel,
  input  logic host_rst,
  input  logic supply_ok,
  output logic supply_en,
  output logic supply_class,
  output logic io_connect,
  output logic clk_en,
  output logic card_rst,
  output logic fault
);
  logic cmd_fall, cmd_rise, linked;

  sc_line_edge #(.WIDTH(1), .IDLE_LEVEL(1'b1)) u_cmd_edge (
    .clk(clk), .rst_n(rst_n), .line(host_cmd_n), .fall(cmd_fall), .rise(cmd_rise)
  );

  sc_act_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode),
    .cmd_fall(cmd_fall), .cmd_rise(cmd_rise),
    .card_present(card_present), .class_sel(class_sel),
    .host_rst(host_rst), .supply_ok(supply_ok),
    .io_q(io_connect), .sup_q(supply_en), .cls_q(supply_class),
    .clk_q(clk_en), .linked_q(linked), .fault_q(fault)
  );

  sc_rst_mux #(.WIDTH(1)) u_rst_mux (
    .hw_sel(hw_mode), .sw_src(sw_rst), .host_src(host_rst),
    .link_en(linked), .rst_out(card_rst)
  );
endmodule

// File: rtl/sc_hwact_seq_chk.sv
module sc_hwact_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic hw_mode,
  input logic card_present,
  input logic host_rst,
  input logic supply_ok,
  input logic supply_en,
  input logic supply_class,
  input logic io_connect,
  input logic clk_en,
  input logic card_rst,
  input logic fault
);
  assert_supply_after_io_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_en) |-> io_connect && $past(io_connect));

  assert_start_needs_card_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_connect) |-> $past(card_present));

  assert_class_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_en && $past(supply_en)) |-> $stable(supply_class));

  assert_clk_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> $past(supply_ok) && !$past(host_rst));

  assert_clk_needs_supply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> supply_en && io_connect);

  assert_rst_low_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && !host_rst) |-> !card_rst);

  assert_rst_needs_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && card_rst) |-> supply_en);

  assert_power_off_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en) |-> !io_connect && !clk_en);

  assert_fault_on_removal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> !$past(card_present));
endmodule

bind sc_hwact_seq sc_hwact_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .card_present(card_present),
  .host_rst(host_rst), .supply_ok(supply_ok), .supply_en(supply_en),
  .supply_class(supply_class), .io_connect(io_connect), .clk_en(clk_en),
  .card_rst(card_rst), .fault(fault)
);

// File: tb/test_sc_hwact_seq.sv
`timescale 1ns/1ps
module test_sc_hwact_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_mode = 1'b1, sw_rst = 1'b0, host_cmd_n = 1'b1, card_present = 1'b1;
  logic class_sel = 1'b0, host_rst = 1'b1, supply_ok = 1'b0;
  logic supply_en, supply_class, io_connect, clk_en, card_rst, fault;
  int   n_chk = 0, n_bad = 0, cyc = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  sc_hwact_seq i_sc_hwact_seq (
    .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .sw_rst(sw_rst),
    .host_cmd_n(host_cmd_n), .card_present(card_present), .class_sel(class_sel),
    .host_rst(host_rst), .supply_ok(supply_ok), .supply_en(supply_en),
    .supply_class(supply_class), .io_connect(io_connect), .clk_en(clk_en),
    .card_rst(card_rst), .fault(fault)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // power-down from an active state; card_rst/clk/io/supply fall in order (R8)
  task automatic power_down(input logic had_clk, input logic glitch);
    host_cmd_n = 1'b1;
    tick();
    check("R8 card_rst low first", card_rst, 1'b0);
    check("R8 clk still on", clk_en, had_clk);
    if (glitch) host_cmd_n = 1'b0;  // R10 fall during power-down
    tick();
    check("R8 clk off", clk_en, 1'b0);
    check("R8 io still on", io_connect, 1'b1);
    tick();
    check("R8 io off", io_connect, 1'b0);
    check("R8 supply still on", supply_en, 1'b1);
    tick();
    check("R8 supply off", supply_en, 1'b0);
    tick();
    check("R10 no restart io", io_connect, 1'b0);
    check("R10 no restart supply", supply_en, 1'b0);
    host_cmd_n = 1'b1;
    supply_ok = 1'b0;
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 io reset", io_connect, 1'b0);
    check("R1 supply reset", supply_en, 1'b0);
    check("R1 clk reset", clk_en, 1'b0);
    check("R1 rst reset", card_rst, 1'b0);
    check("R1 fault reset", fault, 1'b0);
    rst_n = 1'b1;
    tick();
    check("R1 class after reset", supply_class, 1'b0);
    check("R1 io after reset", io_connect, 1'b0);

    for (int cls = 0; cls < 2; cls++) begin
      for (int dly = 0; dly < 4; dly++) begin
        for (int rfirst = 0; rfirst < 2; rfirst++) begin
          class_sel = cls[0]; host_rst = 1'b1; supply_ok = 1'b0;
          tick();
          host_cmd_n = 1'b0;
          tick();
          check("R2 io on", io_connect, 1'b1);
          check("R2 supply not yet", supply_en, 1'b0);
          check("R9 fault clear", fault, 1'b0);
          class_sel = ~cls[0];
          tick();
          check("R2 supply on", supply_en, 1'b1);
          check("R4 class latched", supply_class, cls[0]);
          if (rfirst != 0) host_rst = 1'b0;
          for (int k = 0; k < dly; k++) begin
            tick();
            check("R5 clk waits supply", clk_en, 1'b0);
            check("R6 card_rst low", card_rst, 1'b0);
          end
          supply_ok = 1'b1;
          if (rfirst == 0) begin
            tick();
            check("R5 clk waits host reset", clk_en, 1'b0);
            check("R6 not linked yet", card_rst, 1'b0);
            host_rst = 1'b0;
          end
          tick();
          check("R5 clk on", clk_en, 1'b1);
          check("R4 class kept", supply_class, cls[0]);
          class_sel = cls[0];
          tick();
          host_rst = 1'b1; #1;
          check("R6 card_rst follows", card_rst, 1'b1);
          tick();
          check("R6 card_rst held", card_rst, 1'b1);
          power_down(1'b1, (dly % 2) == 1);
        end
      end
    end

    // R3: no card, no start
    card_present = 1'b0;
    tick();
    host_cmd_n = 1'b0;
    tick();
    check("R3 io stays off", io_connect, 1'b0);
    tick();
    check("R3 supply stays off", supply_en, 1'b0);
    check("R9 no fault in idle", fault, 1'b0);
    host_cmd_n = 1'b1; card_present = 1'b1;
    tick();

    // R9: card removal during supply phase
    host_cmd_n = 1'b0;
    tick(); tick();
    check("R9 powered", supply_en, 1'b1);
    card_present = 1'b0;
    tick();
    check("R9 fault set", fault, 1'b1);
    check("R9 rst low", card_rst, 1'b0);
    tick();
    check("R9 clk off", clk_en, 1'b0);
    check("R9 io held", io_connect, 1'b1);
    tick();
    check("R9 io off", io_connect, 1'b0);
    tick();
    check("R9 supply off", supply_en, 1'b0);
    check("R9 fault sticky", fault, 1'b1);
    card_present = 1'b1; host_cmd_n = 1'b1;
    tick();
    check("R9 fault sticky idle", fault, 1'b1);
    host_cmd_n = 1'b0;
    tick();
    check("R9 fault cleared on start", fault, 1'b0);
    check("R9 restart io", io_connect, 1'b1);
    tick();
    power_down(1'b0, 1'b0);

    // R7: software reset path
    hw_mode = 1'b0;
    for (int v = 0; v < 4; v++) begin
      sw_rst = v[0]; host_rst = v[1]; #1;
      check("R7 sw path", card_rst, v[0]);
      tick();
    end
    host_cmd_n = 1'b0;
    tick();
    check("R7 cmd ignored io", io_connect, 1'b0);
    tick();
    check("R7 cmd ignored supply", supply_en, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_bad = n_bad + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule